// File: doc/BRIEF.md
# Sampling Converter Host Interface

This block drives a 14-bit edge-triggered sampling converter from the host clock domain. It starts running when reset is released. It raises a start pulse once per programmed period, then waits for the converter's end-of-conversion line to drop. At that point it captures the parallel word and passes it on through a valid/ready stream, converting it to two's complement first if the host asks for that. The converter's conversion-busy line is asynchronous to the host clock, so it is resynchronised before any decision is taken on it.

The block protects the converter from misuse. A conversion that is still running is never restarted. The pulse width is always one the converter tolerates. The coding-select and output-enable pins stay fixed while a conversion is in flight. Two faults stay visible in sticky flags: a sample lost because the consumer was not ready, and a conversion that never signalled completion.

Top module: `conv_host_ctrl`

## Requirements
- R1: While reset is held, `adc_start`, `m_valid`, `ovf_sticky` and `timeout_err` are 0. After release the block runs on its own, and the first start pulse rises `max(cfg_period_cycles, 20)` cycles after the first clock edge with reset inactive.
- R2: A requested pulse width of 4 to 8 cycles is used as given: `adc_start` stays high for exactly that many cycles.
- R3: A requested width of 13 to 16 cycles is honoured only when the effective period is above 20 cycles. Any other request gives a pulse of 8 cycles.
- R4: Rising edges of `adc_start` are never closer than the effective period `max(cfg_period_cycles, 20)`. When the previous conversion finished in time, the spacing equals the effective period exactly.
- R5: A start pulse never rises while the synchronised end-of-conversion is high. The line must have been low at the converter pin for at least 3 clock edges first.
- R6: `adc_comp_sel` and `adc_oe_n` follow `cfg_comp_sel` and `~cfg_out_en` only between conversions. From the start pulse until the end of conversion is detected, they are frozen. The two's-complement request is latched at the same moment.
- R7: A falling edge of `adc_eoc` during a conversion captures `adc_data`. The word appears on `m_data` with `m_valid` high 3 clock edges after the pin falls.
- R8: With two's complement off, `m_data` equals the captured pin word. With it on, `m_data` is the offset-binary value with bit 13 inverted. That is the pin word XOR 0x2000 when complement-select was 0, and XOR 0x1FFF when it was 1.
- R9: `m_valid` and `m_data` hold until `m_ready` is seen high. A sample that arrives while an unaccepted one is held is dropped and sets `ovf_sticky`, which stays set until reset.
- R10: If no end-of-conversion fall is detected by 32 cycles after a start pulse rises, `timeout_err` rises on that 32nd edge and stays set. The sequence then returns to idle and starts again, and a late fall is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pulse_cycles | input | 5 | Requested start pulse width in cycles |
| cfg_period_cycles | input | 8 | Requested start period in cycles (minimum 20 enforced) |
| cfg_comp_sel | input | 1 | Requested complement-select level for the converter |
| cfg_out_en | input | 1 | Requested converter output enable (1 = enabled) |
| cfg_twos | input | 1 | Convert captured samples to two's complement |
| adc_eoc | input | 1 | Converter end-of-conversion, asynchronous |
| adc_data | input | 14 | Converter parallel output word |
| m_ready | input | 1 | Stream consumer ready |
| adc_start | output | 1 | Start-convert pulse to the converter |
| adc_comp_sel | output | 1 | Complement-select pin, frozen during conversion |
| adc_oe_n | output | 1 | Active-low output enable pin, frozen during conversion |
| m_valid | output | 1 | Stream sample valid |
| m_data | output | 14 | Stream sample word |
| ovf_sticky | output | 1 | A sample was dropped since reset |
| timeout_err | output | 1 | A conversion timed out since reset |

## Verification
The bench uses the default parameters: a 14-bit word, a 20-cycle minimum period, a 32-cycle timeout and a two-stage synchroniser. With an 8-bit period field, periods on both sides of the 20-cycle floor can be requested, so both the rejection and the acceptance of the long pulse window occur. The 32-cycle timeout sits well above the modelled conversion time of about 22 cycles, yet below a stretched 60-cycle conversion, so the bench can trigger a timeout on purpose. With 5-bit width requests, values inside each window, between them, at zero and at 31 are all exercised.

// File: rtl/conv_host_pkg.sv
package conv_host_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_PULSE = 2'd1,
        PH_WAIT  = 2'd2
    } phase_e;

endpackage

// File: rtl/conv_eoc_sync.sv
module conv_eoc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic eoc_async,
    output logic eoc_s,
    output logic eoc_fall
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sh   = {s_q.sh[STAGES-2:0], eoc_async};
        s_d.prev = s_q.sh[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign eoc_s    = s_q.sh[STAGES-1];
    assign eoc_fall = s_q.prev & ~s_q.sh[STAGES-1];

endmodule

// File: rtl/conv_start_seq.sv
module conv_start_seq
    import conv_host_pkg::*;
#(
    parameter int PW_W    = 5,
    parameter int PER_W   = 8,
    parameter int PW_DEF  = 8,
    parameter int PW_SMIN = 4,
    parameter int PW_SMAX = 8,
    parameter int PW_LMIN = 13,
    parameter int PW_LMAX = 16,
    parameter int PER_MIN = 20,
    parameter int TMO     = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PW_W-1:0]  cfg_width,
    input  logic [PER_W-1:0] cfg_period,
    input  logic             cfg_comp,
    input  logic             cfg_oe,
    input  logic             cfg_twos,
    input  logic             eoc_s,
    input  logic             eoc_fall,
    output logic             start_o,
    output logic             comp_o,
    output logic             oe_n_o,
    output logic             twos_o,
    output logic             capture_o,
    output logic             timeout_o
);
    localparam int TO_W = $clog2(TMO + 1);

    typedef struct packed {
        phase_e           phase;
        logic [PER_W-1:0] per_cnt;
        logic [PW_W-1:0]  pw_cnt;
        logic [TO_W-1:0]  to_cnt;
        logic [PW_W-1:0]  width;
        logic             start;
        logic             comp;
        logic             oe;
        logic             twos;
        logic             tmo;
    } seq_t;

    seq_t s_d, s_q;
    logic [PER_W-1:0] per_eff;

    function automatic logic [PW_W-1:0] pick_width(input logic [PW_W-1:0] w, input logic long_ok);
        if (w >= PW_W'(PW_SMIN) && w <= PW_W'(PW_SMAX)) return w;
        if (long_ok && w >= PW_W'(PW_LMIN) && w <= PW_W'(PW_LMAX)) return w;
        return PW_W'(PW_DEF);
    endfunction

    always_comb begin
        s_d       = s_q;
        capture_o = 1'b0;
        per_eff   = (cfg_period < PER_W'(PER_MIN)) ? PER_W'(PER_MIN) : cfg_period;
        if (s_q.per_cnt != '1) s_d.per_cnt = s_q.per_cnt + 1'b1;
        if (s_q.phase != PH_IDLE && s_q.to_cnt < TO_W'(TMO)) s_d.to_cnt = s_q.to_cnt + 1'b1;

        case (s_q.phase)
            PH_IDLE: begin
                s_d.comp = cfg_comp;
                s_d.oe   = cfg_oe;
                s_d.twos = cfg_twos;
                if (s_q.per_cnt >= per_eff - 1'b1 && !eoc_s) begin
                    s_d.phase   = PH_PULSE;
                    s_d.start   = 1'b1;
                    s_d.pw_cnt  = PW_W'(1);
                    s_d.to_cnt  = TO_W'(1);
                    s_d.per_cnt = '0;
                    s_d.width   = pick_width(cfg_width, per_eff > PER_W'(PER_MIN));
                end
            end
            PH_PULSE: begin
                if (s_q.pw_cnt == s_q.width) begin
                    s_d.start = 1'b0;
                    s_d.phase = PH_WAIT;
                end else begin
                    s_d.pw_cnt = s_q.pw_cnt + 1'b1;
                end
            end
            PH_WAIT: begin
                if (eoc_fall) begin
                    capture_o = 1'b1;
                    s_d.phase = PH_IDLE;
                end else if (s_q.to_cnt >= TO_W'(TMO)) begin
                    s_d.tmo   = 1'b1;
                    s_d.phase = PH_IDLE;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign start_o   = s_q.start;
    assign comp_o    = s_q.comp;
    assign oe_n_o    = ~s_q.oe;
    assign twos_o    = s_q.twos;
    assign timeout_o = s_q.tmo;

    // R5
    rise_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.start) |-> !$past(eoc_s));

    // R2
    width_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.start |-> ((s_q.width >= PW_W'(PW_SMIN) && s_q.width <= PW_W'(PW_SMAX)) ||
                       (s_q.width >= PW_W'(PW_LMIN) && s_q.width <= PW_W'(PW_LMAX))));

    // R6
    ctrl_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase != PH_IDLE && $past(s_q.phase) != PH_IDLE) |->
        ($stable(s_q.comp) && $stable(s_q.oe) && $stable(s_q.twos)));

    // R10
    timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.tmo |=> s_q.tmo);

endmodule

// File: rtl/conv_sample_out.sv
module conv_sample_out #(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] raw,
    input  logic              comp,
    input  logic              twos,
    input  logic              m_ready,
    output logic              m_valid,
    output logic [DATA_W-1:0] m_data,
    output logic              ovf
);
    localparam logic [DATA_W-1:0] MSB_MASK  = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] LOW_MASK  = {1'b0, {(DATA_W-1){1'b1}}};

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              ovf;
    } out_t;

    out_t s_d, s_q;
    logic [DATA_W-1:0] coded;

    always_comb begin
        coded = raw;
        if (twos) coded = raw ^ (comp ? LOW_MASK : MSB_MASK);

        s_d = s_q;
        if (s_q.valid && m_ready) s_d.valid = 1'b0;
        if (capture) begin
            if (s_q.valid && !m_ready) begin
                s_d.ovf = 1'b1;
            end else begin
                s_d.valid = 1'b1;
                s_d.data  = coded;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign m_valid = s_q.valid;
    assign m_data  = s_q.data;
    assign ovf     = s_q.ovf;

    // R9
    hold_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

endmodule

// File: rtl/conv_host_ctrl.sv
module conv_host_ctrl #(
    parameter int DATA_W  = 14,
    parameter int PW_W    = 5,
    parameter int PER_W   = 8,
    parameter int PW_DEF  = 8,
    parameter int PW_SMIN = 4,
    parameter int PW_SMAX = 8,
    parameter int PW_LMIN = 13,
    parameter int PW_LMAX = 16,
    parameter int PER_MIN = 20,
    parameter int TMO     = 32,
    parameter int SYNC_N  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PW_W-1:0]   cfg_pulse_cycles,
    input  logic [PER_W-1:0]  cfg_period_cycles,
    input  logic              cfg_comp_sel,
    input  logic              cfg_out_en,
    input  logic              cfg_twos,
    input  logic              adc_eoc,
    input  logic [DATA_W-1:0] adc_data,
    input  logic              m_ready,
    output logic              adc_start,
    output logic              adc_comp_sel,
    output logic              adc_oe_n,
    output logic              m_valid,
    output logic [DATA_W-1:0] m_data,
    output logic              ovf_sticky,
    output logic              timeout_err
);
    logic eoc_s, eoc_fall, capture, twos_lat;

    conv_eoc_sync #(.STAGES(SYNC_N)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .eoc_async (adc_eoc),
        .eoc_s     (eoc_s),
        .eoc_fall  (eoc_fall)
    );

    conv_start_seq #(
        .PW_W(PW_W), .PER_W(PER_W), .PW_DEF(PW_DEF),
        .PW_SMIN(PW_SMIN), .PW_SMAX(PW_SMAX),
        .PW_LMIN(PW_LMIN), .PW_LMAX(PW_LMAX),
        .PER_MIN(PER_MIN), .TMO(TMO)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_width  (cfg_pulse_cycles),
        .cfg_period (cfg_period_cycles),
        .cfg_comp   (cfg_comp_sel),
        .cfg_oe     (cfg_out_en),
        .cfg_twos   (cfg_twos),
        .eoc_s      (eoc_s),
        .eoc_fall   (eoc_fall),
        .start_o    (adc_start),
        .comp_o     (adc_comp_sel),
        .oe_n_o     (adc_oe_n),
        .twos_o     (twos_lat),
        .capture_o  (capture),
        .timeout_o  (timeout_err)
    );

    conv_sample_out #(.DATA_W(DATA_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .raw     (adc_data),
        .comp    (adc_comp_sel),
        .twos    (twos_lat),
        .m_ready (m_ready),
        .m_valid (m_valid),
        .m_data  (m_data),
        .ovf     (ovf_sticky)
    );

endmodule

// File: tb/conv_host_ctrl_tb_top.sv
module conv_host_ctrl_tb_top;
    localparam int TMO_C = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  cfg_pulse_cycles = 5'd8;
    logic [7:0]  cfg_period_cycles = 8'd30;
    logic        cfg_comp_sel = 1'b0;
    logic        cfg_out_en = 1'b1;
    logic        cfg_twos = 1'b0;
    logic        adc_eoc = 1'b0;
    logic [13:0] adc_data = '0;
    logic        m_ready = 1'b1;
    logic        adc_start, adc_comp_sel, adc_oe_n, m_valid, ovf_sticky, timeout_err;
    logic [13:0] m_data;

    conv_host_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_pulse_cycles(cfg_pulse_cycles), .cfg_period_cycles(cfg_period_cycles),
        .cfg_comp_sel(cfg_comp_sel), .cfg_out_en(cfg_out_en), .cfg_twos(cfg_twos),
        .adc_eoc(adc_eoc), .adc_data(adc_data), .m_ready(m_ready),
        .adc_start(adc_start), .adc_comp_sel(adc_comp_sel), .adc_oe_n(adc_oe_n),
        .m_valid(m_valid), .m_data(m_data), .ovf_sticky(ovf_sticky), .timeout_err(timeout_err)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int rel_cyc = 0;
    int chg_cyc = 0;
    int rise_cnt = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int eff_period(input int p);
        return (p < 20) ? 20 : p;
    endfunction

    function automatic int exp_width(input int w, input int p);
        if (w >= 4 && w <= 8) return w;
        if (w >= 13 && w <= 16 && eff_period(p) > 20) return w;
        return 8;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_err++;
            $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    // behavioural model state
    int          arr_cyc[$];
    logic [13:0] arr_dat[$];
    bit          ref_valid = 0;
    logic [13:0] ref_data = '0;
    bit          ref_ovf = 0;
    bit          st_prev = 0;
    bit          tmo_prev = 0;
    int          rise_cyc = 0;
    int          conv_cnt = 0;
    int          cur_len = 15;
    int          eoc_len = 15;
    int          eoc_low = 0;
    int          samp_idx = 0;
    bit          busy = 0;
    bit          comp_at = 0;
    bit          oe_n_at = 0;
    bit          twos_at = 0;
    logic [13:0] val = '0;
    logic [31:0] rng = 32'h1234_5679;
    int          rdy_mode = 0;
    bit          tog_en = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            // stream reference for the edge just passed
            if (arr_cyc.size() > 0 && arr_cyc[0] == cyc) begin
                if (ref_valid && !m_ready) ref_ovf = 1;
                else begin ref_valid = 1; ref_data = arr_dat[0]; end
                void'(arr_cyc.pop_front());
                void'(arr_dat.pop_front());
            end else if (ref_valid && m_ready) begin
                ref_valid = 0;
            end
            chk(m_valid == ref_valid, "R7 m_valid", int'(m_valid), int'(ref_valid));
            if (ref_valid) chk(m_data == ref_data, "R8 m_data", int'(m_data), int'(ref_data));
            chk(ovf_sticky == ref_ovf, "R9 ovf_sticky", int'(ovf_sticky), int'(ref_ovf));

            eoc_low = adc_eoc ? 0 : eoc_low + 1;

            if (adc_start && !st_prev) begin
                chk(eoc_low >= 3, "R5 eoc low before start", eoc_low, 3);
                if (rise_cnt == 0)
                    chk(cyc - rel_cyc == eff_period(cfg_period_cycles), "R1 first start",
                        cyc - rel_cyc, eff_period(cfg_period_cycles));
                else if (chg_cyc <= rise_cyc) begin
                    if (eff_period(cfg_period_cycles) >= 26 && cur_len < 40)
                        chk(cyc - rise_cyc == eff_period(cfg_period_cycles), "R4 period exact",
                            cyc - rise_cyc, eff_period(cfg_period_cycles));
                    else
                        chk(cyc - rise_cyc >= eff_period(cfg_period_cycles), "R4 period min",
                            cyc - rise_cyc, eff_period(cfg_period_cycles));
                end
                rise_cyc = cyc;
                rise_cnt++;
                busy = 1;
                comp_at = adc_comp_sel;
                oe_n_at = adc_oe_n;
                twos_at = cfg_twos;
                chk(adc_comp_sel == cfg_comp_sel && adc_oe_n == !cfg_out_en, "R6 idle follow",
                    int'({adc_comp_sel, adc_oe_n}), int'({cfg_comp_sel, !cfg_out_en}));
                conv_cnt = 1;
                cur_len = eoc_len;
                case (samp_idx % 8)
                    0: val = 14'h0000;
                    1: val = 14'h3FFF;
                    2: val = 14'h2000;
                    3: val = 14'h1FFF;
                    default: val = rng[13:0];
                endcase
                samp_idx++;
            end else if (!adc_start && st_prev) begin
                if (chg_cyc < rise_cyc - 1)
                    chk(cyc - rise_cyc == exp_width(cfg_pulse_cycles, cfg_period_cycles),
                        (cfg_pulse_cycles >= 13) ? "R3 long window width" : "R2 width",
                        cyc - rise_cyc, exp_width(cfg_pulse_cycles, cfg_period_cycles));
            end
            st_prev = adc_start;

            if (busy)
                chk(adc_comp_sel == comp_at && adc_oe_n == oe_n_at, "R6 frozen pins",
                    int'({adc_comp_sel, adc_oe_n}), int'({comp_at, oe_n_at}));

            if (timeout_err && !tmo_prev)
                chk(cyc - rise_cyc == TMO_C, "R10 timeout delay", cyc - rise_cyc, TMO_C);
            tmo_prev = timeout_err;

            // converter model
            if (conv_cnt > 0 && !(adc_start && cyc == rise_cyc)) begin
                conv_cnt++;
                if (conv_cnt == 4) adc_eoc = 1'b1;
                if (conv_cnt == 4 + cur_len - 1) adc_data = adc_comp_sel ? ~val : val;
                if (conv_cnt == 4 + cur_len) begin
                    adc_eoc = 1'b0;
                    busy = 0;
                    conv_cnt = 0;
                    if (cur_len < 40) begin
                        arr_cyc.push_back(cyc + 3);
                        arr_dat.push_back(twos_at ? (val ^ 14'h2000) : (adc_comp_sel ? ~val : val));
                    end
                end
            end

            rng = {rng[30:0], rng[31] ^ rng[21] ^ rng[1] ^ rng[0]};
            if (tog_en) begin
                if (rng[3:0] == 4'd0) cfg_comp_sel = ~cfg_comp_sel;
                if (rng[7:4] == 4'd1) cfg_out_en = ~cfg_out_en;
                if (rng[11:8] == 4'd2) cfg_twos = ~cfg_twos;
            end
            case (rdy_mode)
                0: m_ready = 1'b1;
                1: m_ready = rng[13];
                default: m_ready = 1'b0;
            endcase
        end
    end

    task automatic set_cfg(input int w, input int p, input bit c, input bit t);
        @(posedge clk); #1;
        cfg_pulse_cycles = w[4:0];
        cfg_period_cycles = p[7:0];
        cfg_comp_sel = c;
        cfg_twos = t;
        chg_cyc = cyc;
    endtask

    task automatic wait_rises(input int n);
        int target;
        target = rise_cnt + n;
        while (rise_cnt < target) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) begin
            @(negedge clk);
            chk(adc_start == 0 && m_valid == 0, "R1 reset outputs", int'({adc_start, m_valid}), 0);
            chk(ovf_sticky == 0 && timeout_err == 0, "R1 reset flags", int'({ovf_sticky, timeout_err}), 0);
        end
        @(posedge clk); #1;
        rst_n = 1'b1;
        rel_cyc = cyc;

        wait_rises(4);
        set_cfg(8, 30, 0, 1); wait_rises(4);
        set_cfg(8, 30, 1, 0); wait_rises(4);
        set_cfg(8, 30, 1, 1); wait_rises(4);
        set_cfg(4, 30, 0, 0); wait_rises(3);
        set_cfg(6, 30, 0, 0); wait_rises(3);
        set_cfg(13, 30, 0, 0); wait_rises(3);
        set_cfg(16, 30, 0, 0); wait_rises(3);
        set_cfg(13, 20, 0, 0); wait_rises(3);
        set_cfg(16, 5, 0, 0); wait_rises(3);
        set_cfg(10, 30, 0, 0); wait_rises(3);
        set_cfg(0, 30, 0, 0); wait_rises(3);
        set_cfg(31, 30, 0, 0); wait_rises(3);
        set_cfg(5, 60, 0, 0); wait_rises(3);
        set_cfg(8, 21, 0, 0); wait_rises(3);
        chk(timeout_err == 0, "R10 no false timeout", int'(timeout_err), 0);
        chk(ovf_sticky == 0, "R9 no false overflow", int'(ovf_sticky), 0);

        set_cfg(7, 30, 0, 1);
        tog_en = 1; rdy_mode = 1;
        wait_rises(12);
        tog_en = 0;
        set_cfg(8, 30, 0, 0);
        rdy_mode = 0;
        wait_rises(2);

        rdy_mode = 2;
        wait_rises(4);
        chk(ovf_sticky == 1, "R9 overflow set", int'(ovf_sticky), 1);
        chk(m_valid == 1, "R9 held sample", int'(m_valid), 1);
        rdy_mode = 0;
        wait_rises(3);
        chk(ovf_sticky == 1, "R9 overflow sticky", int'(ovf_sticky), 1);

        eoc_len = 60;
        wait_rises(2);
        chk(timeout_err == 1, "R10 timeout set", int'(timeout_err), 1);
        eoc_len = 15;
        wait_rises(4);
        chk(timeout_err == 1, "R10 timeout sticky", int'(timeout_err), 1);
        repeat (40) @(posedge clk);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule